// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register front end of a shared-memory adapter that links several compute nodes. Software sees four 32-bit words in the window. The first is an interrupt mask. The second is an interrupt status word, which clears when it is read. The third is a read-only identifier for the local node. The fourth is a doorbell, which asks for a notification vector to be raised on a remote peer. The block drives a level interrupt whenever a status bit and its mask bit are both set. It also drives a one-cycle doorbell request that carries the target peer and vector.

The number of live peers and the number of vectors each peer accepts are inputs. The block therefore checks every doorbell against the current table before it forwards anything. A doorbell that fails the check is dropped and sets a sticky error output. A separate local event input forces the status word to one, so an incoming notification reaches the interrupt line.

Top module: `dbell_regs`

## Requirements
- R1: The word at offset 0x0 is the mask, 0x4 is the status, 0x8 is the node identifier and 0xC is the doorbell. Read data appears on `rd_data` in the cycle after the read request and holds until the next read.
- R2: A write is decoded on its address ANDed with 0xFC, so a write to 0x05 reaches the status word. A read is decoded on the exact offset, so a read of 0x05 returns zero.
- R3: `irq` is high exactly when the bitwise AND of status and mask is non-zero, starting in the cycle after the register change.
- R4: A read of offset 0x4 returns the status value and clears the status to zero in the same access, and `irq` falls accordingly.
- R5: A write to the mask or the status replaces all 32 bits of that register.
- R6: In a doorbell write, bits 31:16 hold the destination peer and bits 7:0 hold the vector. Bits 15:8 are ignored.
- R7: A valid doorbell raises `bell_req` for exactly one cycle, in the cycle after the write, with `bell_peer` and `bell_vec` set from the write.
- R8: A doorbell is dropped when its peer is not below `peer_count`, or when its vector is not below that peer's entry in `vec_counts` (entry p occupies bits 8p+7:8p). A dropped doorbell emits no request and sets `bell_err`, which stays high until reset.
- R9: A `local_event` pulse sets the status to 1. The event wins over a write to the status or a status read-clear in the same cycle, and that read still returns the old status value.
- R10: Synchronous reset clears the mask, the status, `bell_err`, `bell_req` and `rd_data`.
- R11: Reads of the doorbell offset and of undefined offsets return zero. Writes to undefined offsets change no state.
- R12: A read of offset 0x8 returns `node_id` zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset in the register window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| node_id | input | 16 | Identifier of the local node |
| peer_count | input | 3 | Number of live peers |
| vec_counts | input | 32 | Vector count per peer, 8 bits each |
| local_event | input | 1 | Incoming notification for this node |
| irq | output | 1 | Level interrupt |
| bell_req | output | 1 | One-cycle doorbell request |
| bell_peer | output | 16 | Destination peer of the last request |
| bell_vec | output | 8 | Vector of the last request |
| bell_err | output | 1 | Sticky flag for a dropped doorbell |

## Verification
Every result is due one clock edge after its stimulus. This covers read data, the status clear, `irq`, the doorbell pulse and the error flag, because each of them comes out of a register written on that edge. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares all outputs with the model on the next falling edge. A wrong value is therefore caught in the exact cycle it was due, and so is a pulse that comes late or lasts too long.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned PEER_W = 16;
    localparam int unsigned VEC_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_NODE   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_BELL   = 8'h0C;
    localparam logic [ADDR_W-1:0] WORD_MASK  = 8'hFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STATUS,
        SEL_NODE,
        SEL_BELL
    } reg_sel_e;

    typedef struct packed {
        logic [PEER_W-1:0] peer;
        logic [VEC_W-1:0]  vec;
    } bell_t;

    function automatic reg_sel_e decode_ofs(logic [ADDR_W-1:0] a);
        case (a)
            OFS_MASK:   return SEL_MASK;
            OFS_STATUS: return SEL_STATUS;
            OFS_NODE:   return SEL_NODE;
            OFS_BELL:   return SEL_BELL;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic bell_t split_bell(logic [DATA_W-1:0] w);
        bell_t b;
        b.peer = w[31:16];
        b.vec  = w[7:0];
        return b;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output reg_sel_e          wr_sel,
    output reg_sel_e          rd_sel
);
    // writes are word-aligned by masking; reads use the exact offset
    always_comb begin
        wr_sel = SEL_NONE;
        rd_sel = SEL_NONE;
        if (acc_valid) begin
            if (acc_write) wr_sel = decode_ofs(acc_addr & WORD_MASK);
            else           rd_sel = decode_ofs(acc_addr);
        end
    end
endmodule

// File: rtl/dbell_irq_ctrl.sv
module dbell_irq_ctrl
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic              wr_status,
    input  logic              rd_status,
    input  logic              local_event,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] status_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            if (local_event)    status_q <= DATA_W'(1);
            else if (wr_status) status_q <= wdata;
            else if (rd_status) status_q <= '0;
        end
    end

    assign irq = |(status_q & mask_q);

    // R10: reset empties both registers
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && status_q == '0));

    // R9: an event leaves status at exactly one
    p_event_sets_r9: assert property (@(posedge clk) disable iff (rst)
        local_event |=> (status_q == DATA_W'(1)));

    // R5: a mask write lands in full
    p_mask_write_r5: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/dbell_validator.sv
module dbell_validator
    import dbell_pkg::*;
#(
    parameter int unsigned MAX_PEERS = 4,
    localparam int unsigned PCNT_W   = $clog2(MAX_PEERS + 1),
    localparam int unsigned IDX_W    = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bell_wr,
    input  bell_t                      bell_in,
    input  logic [PCNT_W-1:0]          peer_count,
    input  logic [MAX_PEERS*VEC_W-1:0] vec_counts,
    output logic                       req,
    output logic [PEER_W-1:0]          req_peer,
    output logic [VEC_W-1:0]           req_vec,
    output logic                       err
);
    logic [VEC_W-1:0] vec_tbl [MAX_PEERS];

    for (genvar p = 0; p < MAX_PEERS; p++) begin : g_tbl
        assign vec_tbl[p] = vec_counts[p*VEC_W +: VEC_W];
    end

    logic peer_live;
    logic vec_ok;
    logic bell_ok;

    always_comb begin
        peer_live = (bell_in.peer < PEER_W'(peer_count)) &&
                    (bell_in.peer < PEER_W'(MAX_PEERS));
        vec_ok = 1'b0;
        if (peer_live)
            vec_ok = bell_in.vec < vec_tbl[bell_in.peer[IDX_W-1:0]];
        bell_ok = peer_live && vec_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= 1'b0;
            req_peer <= '0;
            req_vec  <= '0;
            err      <= 1'b0;
        end else begin
            req <= bell_wr && bell_ok;
            if (bell_wr && bell_ok) begin
                req_peer <= bell_in.peer;
                req_vec  <= bell_in.vec;
            end
            if (bell_wr && !bell_ok) err <= 1'b1;
        end
    end

    // R7: every request comes from a doorbell write one cycle earlier
    p_req_source_r7: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(bell_wr));

    // R8: a dead destination never produces a request and flags the error
    p_dead_peer_r8: assert property (@(posedge clk) disable iff (rst)
        (bell_wr && bell_in.peer >= PEER_W'(peer_count)) |=> (!req && err));

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
    import dbell_pkg::*;
#(
    parameter int unsigned MAX_PEERS = 4,
    parameter int unsigned NODE_W    = 16,
    localparam int unsigned PCNT_W   = $clog2(MAX_PEERS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [DATA_W-1:0]          acc_wdata,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NODE_W-1:0]          node_id,
    input  logic [PCNT_W-1:0]          peer_count,
    input  logic [MAX_PEERS*VEC_W-1:0] vec_counts,
    input  logic                       local_event,
    output logic                       irq,
    output logic                       bell_req,
    output logic [PEER_W-1:0]          bell_peer,
    output logic [VEC_W-1:0]           bell_vec,
    output logic                       bell_err
);
    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] rd_next;

    dbell_decode u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    dbell_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .wr_mask     (wr_sel == SEL_MASK),
        .wr_status   (wr_sel == SEL_STATUS),
        .rd_status   (rd_sel == SEL_STATUS),
        .local_event (local_event),
        .wdata       (acc_wdata),
        .mask_q      (mask_q),
        .status_q    (status_q),
        .irq         (irq)
    );

    dbell_validator #(.MAX_PEERS(MAX_PEERS)) u_val (
        .clk        (clk),
        .rst        (rst),
        .bell_wr    (wr_sel == SEL_BELL),
        .bell_in    (split_bell(acc_wdata)),
        .peer_count (peer_count),
        .vec_counts (vec_counts),
        .req        (bell_req),
        .req_peer   (bell_peer),
        .req_vec    (bell_vec),
        .err        (bell_err)
    );

    always_comb begin
        case (rd_sel)
            SEL_MASK:   rd_next = mask_q;
            SEL_STATUS: rd_next = status_q;
            SEL_NODE:   rd_next = DATA_W'(node_id);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                      rd_data <= '0;
        else if (acc_valid && !acc_write) rd_data <= rd_next;
    end

    // R4: a plain status read leaves the interrupt low afterwards
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SEL_STATUS && !local_event) |=> !irq);

    // R11: undefined offsets read back as zero
    p_undef_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && rd_sel == SEL_NONE) |=> (rd_data == '0));
endmodule

// File: tb/sim_dbell_regs.sv
module sim_dbell_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write, local_event;
    logic [7:0]  acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] rd_data;
    logic [15:0] node_id;
    logic [2:0]  peer_count;
    logic [31:0] vec_counts;
    logic        irq, bell_req, bell_err;
    logic [15:0] bell_peer;
    logic [7:0]  bell_vec;

    always #2.5 clk = ~clk;

    dbell_regs u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .node_id(node_id), .peer_count(peer_count), .vec_counts(vec_counts),
        .local_event(local_event), .irq(irq), .bell_req(bell_req),
        .bell_peer(bell_peer), .bell_vec(bell_vec), .bell_err(bell_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R10";

    // behavioural reference state
    logic [31:0] m_mask, m_status, m_rd;
    logic        m_req, m_err;
    logic [15:0] m_peer;
    logic [7:0]  m_vec;

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h00) return m_mask;
        if (a == 8'h04) return m_status;
        if (a == 8'h08) return {16'h0, node_id};
        return 32'h0;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_mask = 0; m_status = 0; m_rd = 0; m_req = 0; m_err = 0;
            m_peer = 0; m_vec = 0;
        end else begin
            logic [31:0] old_status = m_status;
            m_req = 0;
            if (acc_valid && !acc_write) begin
                m_rd = m_read(acc_addr);
                if (acc_addr == 8'h04) m_status = 0;
            end
            if (acc_valid && acc_write) begin
                case (acc_addr & 8'hFC)
                    8'h00: m_mask = acc_wdata;
                    8'h04: m_status = acc_wdata;
                    8'h0C: begin
                        int p = int'(acc_wdata[31:16]);
                        int v = int'(acc_wdata[7:0]);
                        if (p < int'(peer_count) && p < 4 &&
                            v < int'(vec_counts[p*8 +: 8])) begin
                            m_req = 1; m_peer = acc_wdata[31:16]; m_vec = acc_wdata[7:0];
                        end else m_err = 1;
                    end
                    default: ;
                endcase
            end
            if (local_event) m_status = 32'h1;
            if (old_status === 32'hx) m_status = m_status;
        end
    endtask

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp("rd_data", rd_data, m_rd);
        cmp("irq", 32'(irq), 32'(|(m_status & m_mask)));
        cmp("bell_req", 32'(bell_req), 32'(m_req));
        cmp("bell_peer", 32'(bell_peer), 32'(m_peer));
        cmp("bell_vec", 32'(bell_vec), 32'(m_vec));
        cmp("bell_err", 32'(bell_err), 32'(m_err));
        acc_valid = 0; acc_write = 0; local_event = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
        tick();
    endtask

    task automatic rd(logic [7:0] a);
        acc_valid = 1; acc_write = 0; acc_addr = a;
        tick();
    endtask

    initial begin
        acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0;
        local_event = 0; node_id = 16'h002A; peer_count = 3;
        vec_counts = {8'd7, 8'd5, 8'd0, 8'd2};
        rst = 1;
        @(negedge clk);
        tag = "R10"; tick(); tick();
        rst = 0;
        tag = "R12"; rd(8'h08);
        tag = "R1";  rd(8'h00); rd(8'h04);
        tag = "R5";  wr(8'h00, 32'hFFFF_0001); rd(8'h00);
        tag = "R3";  wr(8'h04, 32'h0000_0010); tick();
                     wr(8'h04, 32'h8000_0001); tick();
        tag = "R4";  rd(8'h04); rd(8'h04);
        tag = "R9";  local_event = 1; tick(); tick();
                     wr(8'h04, 32'h0000_0300); rd(8'h04);
                     wr(8'h04, 32'h0000_0300);
                     local_event = 1; rd(8'h04); rd(8'h04);
                     local_event = 1; wr(8'h04, 32'h0001_0000); rd(8'h04);
        tag = "R2";  wr(8'h05, 32'h0000_0001); rd(8'h05); rd(8'h04);
                     wr(8'h03, 32'h0000_00F0); rd(8'h00);
        tag = "R7";  wr(8'h0C, 32'h0002_0004); tick();
                     wr(8'h0C, 32'h0000_0001); wr(8'h0C, 32'h0002_0000); tick();
        tag = "R6";  wr(8'h0E, 32'h0002_FF03); tick();
        tag = "R8";  wr(8'h0C, 32'h0003_0000); tick();
                     rst = 1; tick(); rst = 0;
                     wr(8'h0C, 32'h0000_0002); tick();
                     rst = 1; tick(); rst = 0;
                     wr(8'h0C, 32'h0001_0000); tick();
                     wr(8'h0C, 32'h0100_0000); tick();
                     wr(8'h0C, 32'h0002_0004); tick();
        tag = "R11"; wr(8'h00, 32'h0000_00FF); rd(8'h0C); rd(8'h10); rd(8'hFC);
                     wr(8'h20, 32'hDEAD_BEEF); wr(8'h10, 32'h1234_5678);
                     rd(8'h00); rd(8'h04);
        tag = "R10"; wr(8'h04, 32'h0000_0001); rst = 1; tick(); rst = 0;
                     rd(8'h00); rd(8'h04);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule